// File: doc/BRIEF.md
# Edge-Timing Bit Error Rate Monitor

This block estimates the error rate of a recovered serial stream without knowing what the data should be. A phase detector flags, for each recovered bit, whether a data transition was seen and whether that transition fell inside the expected timing window. Every transition that falls outside the window is taken as one bit error. The monitor counts these errors over a measurement window whose length is set by a threshold exponent code. At the end of each window it drives an active-low alarm if the count exceeded a fixed limit.

The threshold is logarithmic. A 3-bit code selects a rate of 10^-10 through 10^-6 errors per bit. The window is sized so that the threshold rate yields exactly `ERR_LIMIT` errors, which makes one comparison serve every code. The alarm has no hysteresis: each window is judged on its own count. Pulling `enable` low switches the function off and holds the alarm deasserted.

Top module: `edge_ber_monitor`

## Requirements
- R1: On a cycle with `bitStrobe` high and `enable` high, one error is counted when `edgeSeen` is 1 and `inWindow` is 0. An edge inside the window, or a bit with `edgeSeen` 0, adds nothing.
- R2: `thrCode` value c in 0..4 selects a threshold of 10^-(10-c) errors per bit (0 gives 10^-10, 4 gives 10^-6). Codes 5, 6 and 7 act exactly like code 4.
- R3: A measurement window spans `ERR_LIMIT` × `RATE_BASE`^(10-c) bit strobes. The code is sampled on the first strobe of the window, and later changes to `thrCode` do not alter that window's length.
- R4: At the end of a window, `alarmN` becomes 0 if the window counted more than `ERR_LIMIT` errors, and becomes 1 otherwise. A count of exactly `ERR_LIMIT` leaves it at 1.
- R5: `alarmN` changes only in the cycle after a window's final strobe, or through disable or reset. Each window is judged alone, with no hysteresis.
- R6: The error count saturates and cannot wrap, so any number of errors above the limit asserts the alarm. The next window starts counting from zero.
- R7: While `enable` is 0, `alarmN` is held at 1 and the window and error counts are cleared. When `enable` returns to 1, a fresh window starts.
- R8: A synchronous `rst` sets `alarmN` to 1 and clears the window and error counts.
- R9: Cycles with `bitStrobe` low neither advance the window nor count errors, whatever `edgeSeen` and `inWindow` show.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Monitor enable; low holds the alarm deasserted |
| bitStrobe | input | 1 | One recovered bit period has elapsed |
| edgeSeen | input | 1 | A data transition occurred in this bit |
| inWindow | input | 1 | The transition fell inside the expected timing window |
| thrCode | input | 3 | Threshold exponent code; rate 10^-(10-code) |
| alarmN | output | 1 | Rate alarm, active low |

## Verification
With the default parameters, the longest window is 10^11 bits, which no bench can reach. The bench therefore builds the block with `ERR_LIMIT` = 3 and `RATE_BASE` = 2, which gives windows of 3072 down to 192 bits. Every code, the exact-limit boundary, saturation, a mid-window code change and disable in the middle of a window can then be driven to a window end many times in a short run. The window-length arithmetic and the comparison are the same at any base, so these runs exercise the structure used by the default build.

// File: rtl/ber_pkg.sv
package ber_pkg;

  localparam int CODE_W    = 3;
  localparam int NUM_CODES = 5;
  localparam int EXP_HI    = 10;

  typedef struct packed {
    logic countEn;
    logic windowEnd;
    logic clear;
  } ber_strobe_t;

  function automatic longint unsigned win_len(input int code, input int limit, input int base);
    longint unsigned r;
    r = 64'(limit);
    for (int i = 0; i < EXP_HI - code; i++) begin
      r = r * 64'(base);
    end
    return r;
  endfunction

endpackage

// File: rtl/ber_ctrl.sv
module ber_ctrl
  import ber_pkg::*;
#(
  parameter int ERR_LIMIT = 10,
  parameter int RATE_BASE = 10,
  parameter int WIN_W     = 37
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              bitStrobe,
  input  logic [CODE_W-1:0] thrCode,
  output ber_strobe_t       strb
);

  localparam int TAB_N = 2 ** CODE_W;

  logic [WIN_W-1:0]  lenTab [TAB_N];
  logic [WIN_W-1:0]  bitCount;
  logic [CODE_W-1:0] activeCode;
  logic [CODE_W-1:0] clampCode;
  logic [CODE_W-1:0] effCode;
  logic              lastBit;

  for (genvar i = 0; i < TAB_N; i++) begin : g_len
    localparam int CI = (i < NUM_CODES) ? i : NUM_CODES - 1;
    assign lenTab[i] = WIN_W'(win_len(CI, ERR_LIMIT, RATE_BASE));
  end

  always_comb begin
    clampCode = (thrCode > CODE_W'(NUM_CODES - 1)) ? CODE_W'(NUM_CODES - 1) : thrCode;
    effCode   = (bitCount == '0) ? clampCode : activeCode;
    lastBit   = (bitCount == lenTab[effCode] - WIN_W'(1));
    strb.clear     = ~enable;
    strb.countEn   = enable & bitStrobe;
    strb.windowEnd = enable & bitStrobe & lastBit;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      bitCount   <= '0;
      activeCode <= '0;
    end else if (bitStrobe) begin
      if (bitCount == '0) activeCode <= clampCode;
      if (lastBit) bitCount <= '0;
      else         bitCount <= bitCount + WIN_W'(1);
    end
  end

  // R3
  bit_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    (bitCount != '0) |-> (bitCount < lenTab[activeCode]));

  // R9
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !bitStrobe) |=> $stable(bitCount));

  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    activeCode < CODE_W'(NUM_CODES));

endmodule

// File: rtl/ber_datapath.sv
module ber_datapath
  import ber_pkg::*;
#(
  parameter int ERR_LIMIT = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  ber_strobe_t strb,
  input  logic        edgeSeen,
  input  logic        inWindow,
  output logic        alarmN
);

  localparam int CNT_W = $clog2(ERR_LIMIT + 2);
  localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(ERR_LIMIT + 1);

  logic [CNT_W-1:0] errCount;
  logic [CNT_W-1:0] nextCount;
  logic             errHit;

  always_comb begin
    errHit    = strb.countEn & edgeSeen & ~inWindow;
    nextCount = (errHit && errCount != SAT_VAL) ? errCount + CNT_W'(1) : errCount;
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clear) begin
      errCount <= '0;
      alarmN   <= 1'b1;
    end else if (strb.windowEnd) begin
      alarmN   <= ~(nextCount > CNT_W'(ERR_LIMIT));
      errCount <= '0;
    end else begin
      errCount <= nextCount;
    end
  end

  // R6
  sat_limit_chk: assert property (@(posedge clk) disable iff (rst)
    errCount <= SAT_VAL);

  // R5
  alarm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.windowEnd && !strb.clear) |=> $stable(alarmN));

  // R7
  disable_high_chk: assert property (@(posedge clk) disable iff (rst)
    strb.clear |=> alarmN);

  // R1
  in_window_free_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.countEn && !(edgeSeen && !inWindow) && !strb.windowEnd && !strb.clear)
      |=> $stable(errCount));

endmodule

// File: rtl/edge_ber_monitor.sv
module edge_ber_monitor
  import ber_pkg::*;
#(
  parameter int ERR_LIMIT = 10,
  parameter int RATE_BASE = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              bitStrobe,
  input  logic              edgeSeen,
  input  logic              inWindow,
  input  logic [CODE_W-1:0] thrCode,
  output logic              alarmN
);

  localparam int WIN_W = $clog2(win_len(0, ERR_LIMIT, RATE_BASE) + 64'd1);

  ber_strobe_t strb;

  ber_ctrl #(
    .ERR_LIMIT(ERR_LIMIT),
    .RATE_BASE(RATE_BASE),
    .WIN_W    (WIN_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .bitStrobe(bitStrobe),
    .thrCode  (thrCode),
    .strb     (strb)
  );

  ber_datapath #(
    .ERR_LIMIT(ERR_LIMIT)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .edgeSeen(edgeSeen),
    .inWindow(inWindow),
    .alarmN  (alarmN)
  );

  // R8
  reset_clear_chk: assert property (@(posedge clk) rst |=> alarmN);

endmodule

// File: tb/tb_edge_ber_monitor.sv
module tb_edge_ber_monitor;

  localparam int K    = 3;
  localparam int BASE = 2;

  logic       clk = 1'b0;
  logic       rst;
  logic       enable;
  logic       bitStrobe;
  logic       edgeSeen;
  logic       inWindow;
  logic [2:0] thrCode;
  logic       alarmN;

  always #5 clk = ~clk;

  edge_ber_monitor #(.ERR_LIMIT(K), .RATE_BASE(BASE)) dut (
    .clk(clk), .rst(rst), .enable(enable), .bitStrobe(bitStrobe),
    .edgeSeen(edgeSeen), .inWindow(inWindow), .thrCode(thrCode), .alarmN(alarmN)
  );

  int   checks = 0;
  int   errors = 0;
  int   cycles = 0;
  int   bitIdx = 0;
  int   errCnt = 0;
  int   curCode = 0;
  logic expAlarm = 1'b1;

  function automatic int expLen(input int code);
    int c;
    c = (code > 4) ? 4 : code;
    return K * (BASE ** (10 - c));
  endfunction

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s alarmN got %0b expected %0b at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  task automatic step(input logic s, input logic e, input logic w, input string tag);
    bitStrobe = s;
    edgeSeen  = e;
    inWindow  = w;
    @(posedge clk);
    #1;
    if (rst || !enable) begin
      bitIdx = 0; errCnt = 0; expAlarm = 1'b1;
    end else if (s) begin
      if (bitIdx == 0) curCode = int'(thrCode);
      if (e && !w) errCnt++;
      bitIdx++;
      if (bitIdx == expLen(curCode)) begin
        expAlarm = (errCnt > K) ? 1'b0 : 1'b1;
        bitIdx = 0;
        errCnt = 0;
      end
    end
    check(tag, alarmN, expAlarm);
  endtask

  task automatic runWindow(input int code, input int nErr, input int switchTo, input string tag);
    int len;
    thrCode = 3'(code);
    len = expLen(code);
    for (int i = 0; i < len; i++) begin
      logic e;
      if ($urandom % 5 == 0) step(1'b0, 1'b1, 1'b0, "R9");
      if (((i + 1) * nErr) / len != (i * nErr) / len) begin
        step(1'b1, 1'b1, 1'b0, tag);
      end else begin
        e = 1'($urandom % 2);
        step(1'b1, e, e ? 1'b1 : 1'($urandom % 2), tag);
      end
      if (i == 0 && switchTo >= 0) thrCode = 3'(switchTo);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; enable = 1'b0; bitStrobe = 1'b0; edgeSeen = 1'b0; inWindow = 1'b0; thrCode = 3'd4;
    repeat (3) step(1'b0, 1'b0, 1'b0, "R8");
    rst = 1'b0;
    check("R8", alarmN, 1'b1);
    enable = 1'b1;

    // R4: zero errors, exactly the limit, one over, then clean again (R5)
    runWindow(4, 0, -1, "R4");
    runWindow(4, K, -1, "R4");
    runWindow(4, K + 1, -1, "R4");
    runWindow(4, 0, -1, "R5");
    // R1: many in-window edges with few out-of-window ones
    runWindow(2, 2, -1, "R1");
    runWindow(2, 4, -1, "R1");
    // R2: clamped codes behave as code 4
    runWindow(7, K + 1, -1, "R2");
    runWindow(5, 0, -1, "R2");
    // R6: saturation then a clean window
    runWindow(4, 100, -1, "R6");
    runWindow(4, 2, -1, "R6");
    // R3: code changed after first bit does not change length
    runWindow(4, 5, 0, "R3");
    runWindow(3, 4, -1, "R3");
    runWindow(1, 6, 4, "R3");

    // R7: disable mid-window
    runWindow(4, 10, -1, "R7");
    thrCode = 3'd4;
    for (int i = 0; i < 50; i++) step(1'b1, 1'b1, 1'b0, "R7");
    enable = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, "R7");
    enable = 1'b1;
    runWindow(4, 0, -1, "R7");

    // R8: reset while the alarm is asserted
    runWindow(4, 10, -1, "R8");
    rst = 1'b1;
    step(1'b1, 1'b1, 1'b0, "R8");
    rst = 1'b0;
    runWindow(4, 1, -1, "R8");

    // random windows
    for (int w = 0; w < 12; w++) begin
      runWindow(int'($urandom % 8), int'($urandom % 8), -1, "R4");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule